// File: doc/BRIEF.md
# Microphone Privacy Zeroing Policy Engine

This block decides, cycle by cycle, which audio capture links must have their sample data replaced with zeros because the user has asked for the microphone to be muted through a privacy switch. It holds a 32-bit policy word that trusted software writes once and may then freeze. The word sets a timeout length, a zeroing mode, an optional input filter and an eight-bit mask of the links that are affected. The privacy switch arrives as an asynchronous level. It is synchronized, optionally filtered, and then drives a state machine. A slow real-time clock enable paces both the timeout and the filter.

In dynamic mode, an asserted privacy level starts a timeout that counts real-time ticks. Zeroing of the masked links begins only after that timeout has run out, which gives firmware time to quiesce its streams gracefully. When the privacy level drops, zeroing stops in that cycle and any unfinished timeout is discarded. In static mode the masked links are zeroed at all times and a force-disable flag is raised. When firmware declares that it manages privacy itself, all hardware zeroing and indication is switched off.

The state machine has six states. FWOWN means firmware has taken over. OFF means zeroing is disabled. IDLE means dynamic mode with privacy released. WAIT means the timeout is counting. ZERO means dynamic zeroing is in force. FORCE means static zeroing. Transitions are checked in a fixed order of priority:
- Any state goes to FWOWN while the firmware input is high.
- Otherwise, any state goes to FORCE in static mode.
- Otherwise, any state goes to OFF in a disabled mode.
- In dynamic mode, FWOWN, OFF and FORCE go to IDLE.
- IDLE goes to WAIT on privacy.
- WAIT goes to IDLE on release, or to ZERO on expiry.
- ZERO goes to IDLE on release.

Top module: `mic_guard_top`

## Requirements
- R1: After reset the policy word reads 0 and link_zero, mic_off_ind and force_off are all 0.
- R2: The policy read word has the following layout. Bits 31:28 always read 0, even when ones are written to them.

  | Bits | Field |
  |------|-------|
  | 27:20 | link mask |
  | 19 | lock |
  | 18 | filter enable |
  | 17:16 | mode |
  | 15:0 | wait count |

- R3: The write that sets the lock bit (bit 19) stores all of its fields. While the lock bit is 1, every later write is ignored. The lock bit clears only on reset.
- R4: In mode 00 or 01, link_zero stays 0 whatever the privacy input does.
- R5: In mode 11, link_zero equals the link mask and force_off is 1, regardless of the privacy input and with no timeout.
- R6: In mode 10, zeroing starts only after the filtered privacy level has stayed high while the wait count of rtc_tick pulses was counted. Clock cycles without rtc_tick do not advance the count.
- R7: In mode 10, link_zero drops to 0 in the same cycle that the filtered privacy level falls. A partial count is discarded, and the next assertion counts again from 0.
- R8: link_zero[i] is driven only when mask bit i is 1. Bits 6:0 serve the serial audio link segments and bit 7 serves the digital microphone link.
- R9: mic_off_ind is 1 exactly while zeroing is in force, in either the ZERO or the FORCE state.
- R10: With the filter enable at 1, a new privacy level is accepted only after it has been seen on 4 consecutive rtc_tick pulses, following a two-flop synchronizer. With the filter enable at 0, the synchronized level passes after one more register.
- R11: While fw_managed is 1, link_zero, mic_off_ind and force_off are 0, and a pending timeout is cancelled.
- R12: If fw_managed rises in the same cycle as the final timeout tick, the firmware takeover wins and no zeroing occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| rtc_tick | input | 1 | One-cycle enable from the slow real-time clock |
| cfg_wr_en | input | 1 | Policy word write strobe |
| cfg_wr_data | input | 32 | Policy word write value |
| cfg_rd_data | output | 32 | Current policy word |
| privacy_raw | input | 1 | Asynchronous privacy request level |
| fw_managed | input | 1 | Firmware takes over privacy handling |
| link_zero | output | 8 | Per-link zero-enable |
| mic_off_ind | output | 1 | Mic-disabled indicator |
| force_off | output | 1 | Static force-disable flag |

## Verification
Two events can land in the same cycle: the last timeout tick that would move WAIT into ZERO, and a firmware takeover. The bench waits in WAIT one tick short of the limit. It then drives rtc_tick and fw_managed high on the same edge and checks that no link is ever zeroed. After fw_managed is released, it checks that the timeout restarts from zero. The other collision is privacy release against a running count. This is judged by showing that a later assertion needs the full count again.

// File: rtl/mg_pkg.sv
package mg_pkg;
    localparam int WAIT_W   = 16;
    localparam int LINK_N   = 8;
    localparam int REG_W    = 32;
    localparam int STABLE_N = 4;

    typedef enum logic [1:0] {
        MD_OFF0   = 2'b00,
        MD_OFF1   = 2'b01,
        MD_DYN    = 2'b10,
        MD_STATIC = 2'b11
    } zmode_e;

    typedef enum logic [2:0] {
        ST_FWOWN,
        ST_OFF,
        ST_IDLE,
        ST_WAIT,
        ST_ZERO,
        ST_FORCE
    } zstate_e;

    // packed from the top bit down: mask, lock, filter enable, mode, wait count
    typedef struct packed {
        logic [LINK_N-1:0] mask;
        logic              lock;
        logic              dge;
        zmode_e            mode;
        logic [WAIT_W-1:0] wait_t;
    } policy_t;

    localparam int POL_W = $bits(policy_t);
endpackage

// File: rtl/mg_policy_reg.sv
module mg_policy_reg
    import mg_pkg::*;
#(
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output policy_t       pol,
    output logic [RW-1:0] rd_data
);
    localparam int PAD_W = RW - POL_W;

    policy_t pol_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q <= '0;
        end else if (wr_en && !pol_q.lock) begin
            pol_q <= policy_t'(wr_data[POL_W-1:0]);
        end
    end

    assign pol     = pol_q;
    assign rd_data = {{PAD_W{1'b0}}, pol_q};

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pol_q.lock |=> pol_q.lock);                                   // R3
    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        pol_q.lock |=> $stable(pol_q));                               // R3
    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pol_q.lock) |=> (rd_data[POL_W-1:0] == $past(wr_data[POL_W-1:0]))); // R2
endmodule

// File: rtl/mg_deglitch.sv
module mg_deglitch #(
    parameter int STABLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic filt_en,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(STABLE + 1);

    logic          s1, s2, level_q;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1      <= 1'b0;
            s2      <= 1'b0;
            level_q <= 1'b0;
            cnt     <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (!filt_en) begin
                level_q <= s2;
                cnt     <= '0;
            end else if (s2 == level_q) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == CW'(STABLE - 1)) begin
                    level_q <= s2;
                    cnt     <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign level = level_q;

    AST_DG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_en) && (level_q != $past(level_q))) |-> $past(tick)); // R10
endmodule

// File: rtl/mg_tick_timer.sv
module mg_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick && (cnt < limit)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt >= limit);

    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !$past(tick)) |-> $stable(cnt));        // R6
    AST_TMR_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!run) && run) |-> (cnt == '0));                        // R7
endmodule

// File: rtl/mg_zero_fsm.sv
module mg_zero_fsm
    import mg_pkg::*;
#(
    parameter int NL = LINK_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  zmode_e        mode,
    input  logic          priv,
    input  logic          fw_own,
    input  logic          expired,
    input  logic [NL-1:0] mask,
    output logic          counting,
    output logic [NL-1:0] link_zero,
    output logic          ind,
    output logic          force_off
);
    zstate_e st, nxt;
    logic    zero_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        if (fw_own) begin
            nxt = ST_FWOWN;
        end else if (mode == MD_STATIC) begin
            nxt = ST_FORCE;
        end else if (mode != MD_DYN) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_IDLE: if (priv) nxt = ST_WAIT;
                ST_WAIT: begin
                    if (!priv)        nxt = ST_IDLE;
                    else if (expired) nxt = ST_ZERO;
                end
                ST_ZERO: if (!priv) nxt = ST_IDLE;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        zero_act  = 1'b0;
        force_off = 1'b0;
        counting  = 1'b0;
        unique case (st)
            ST_WAIT:  counting = 1'b1;
            ST_ZERO:  zero_act = priv && !fw_own;
            ST_FORCE: begin
                zero_act  = !fw_own;
                force_off = !fw_own;
            end
            default: ;
        endcase
        ind = zero_act;
    end

    for (genvar i = 0; i < NL; i++) begin : g_link
        assign link_zero[i] = zero_act & mask[i];
    end

    AST_ZERO_VIA_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ZERO && $past(st) != ST_ZERO) |-> ($past(st) == ST_WAIT)); // R6
    AST_RELEASE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_DYN && !priv) |-> (link_zero == '0 && !ind));          // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && $stable(mode)) |-> (link_zero == '0));                // R4
    AST_FORCE_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
        force_off |-> ($past(mode) == MD_STATIC));                          // R5
    AST_FW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fw_own |-> (link_zero == '0 && !ind && !force_off));                // R11
    AST_IND_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (link_zero != '0) |-> ind);                                         // R9
endmodule

// File: rtl/mic_guard_top.sv
module mic_guard_top
    import mg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic              privacy_raw,
    input  logic              fw_managed,
    output logic [LINK_N-1:0] link_zero,
    output logic              mic_off_ind,
    output logic              force_off
);
    policy_t pol;
    logic    priv_f;
    logic    counting;
    logic    expired;

    mg_policy_reg #(.RW(REG_W)) u_pol (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .pol     (pol),
        .rd_data (cfg_rd_data)
    );

    mg_deglitch #(.STABLE(STABLE_N)) u_dg (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (rtc_tick),
        .filt_en (pol.dge),
        .raw     (privacy_raw),
        .level   (priv_f)
    );

    mg_tick_timer #(.W(WAIT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (counting && !fw_managed),
        .tick    (rtc_tick),
        .limit   (pol.wait_t),
        .expired (expired)
    );

    mg_zero_fsm #(.NL(LINK_N)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (pol.mode),
        .priv      (priv_f),
        .fw_own    (fw_managed),
        .expired   (expired),
        .mask      (pol.mask),
        .counting  (counting),
        .link_zero (link_zero),
        .ind       (mic_off_ind),
        .force_off (force_off)
    );

    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[REG_W-1:POL_W] == '0);                                // R2
    AST_MASK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (link_zero & ~cfg_rd_data[POL_W-1:POL_W-LINK_N]) == '0);          // R8
endmodule

// File: tb/mic_guard_top_test.sv
module mic_guard_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        privacy_raw = 1'b0;
    logic        fw_managed = 1'b0;
    logic [7:0]  link_zero;
    logic        mic_off_ind;
    logic        force_off;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] z;
        logic       ind;
        logic       frc;
    } exp_t;

    exp_t sbq[$];
    event mon_ev;

    always #2 clk = ~clk;

    mic_guard_top uut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .privacy_raw(privacy_raw), .fw_managed(fw_managed),
        .link_zero(link_zero), .mic_off_ind(mic_off_ind), .force_off(force_off)
    );

    initial begin : monitor
        exp_t e;
        forever begin
            @(mon_ev);
            while (sbq.size() > 0) begin
                e = sbq.pop_front();
                n_cmp++;
                if (link_zero !== e.z || mic_off_ind !== e.ind || force_off !== e.frc) begin
                    n_bad++;
                    $display("FAIL %s: got z=%02h ind=%0b frc=%0b expected z=%02h ind=%0b frc=%0b",
                             e.tag, link_zero, mic_off_ind, force_off, e.z, e.ind, e.frc);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [7:0] z, input logic ind, input logic frc);
        exp_t e;
        e.tag = tag; e.z = z; e.ind = ind; e.frc = frc;
        sbq.push_back(e);
        -> mon_ev;
        #1;
    endtask

    task automatic chk_rd(input string tag, input logic [31:0] exp_v);
        n_cmp++;
        if (cfg_rd_data !== exp_v) begin
            n_bad++;
            $display("FAIL %s: got rd=%08h expected rd=%08h", tag, cfg_rd_data, exp_v);
        end
    endtask

    function automatic logic [31:0] pol(input logic [15:0] w, input logic [1:0] m,
                                        input logic d, input logic l, input logic [7:0] k);
        return {4'h0, k, l, d, m, w};
    endfunction

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        repeat (n) begin
            @(negedge clk); rtc_tick = 1'b1;
            @(negedge clk); rtc_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R1..: got hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin : driver
        do_reset();
        // R1 reset state
        chk_rd("R1 reset read", 32'h0);
        expect_out("R1 reset outputs", 8'h00, 1'b0, 1'b0);

        // R2 layout, reserved bits read zero; R4 mode 01 ignores privacy
        wr(pol(16'h1234, 2'b01, 1'b0, 1'b0, 8'hA5) | 32'hF000_0000);
        chk_rd("R2 layout", 32'h0A51_1234);
        privacy_raw = 1'b1; cyc(6);
        expect_out("R4 mode01 privacy high", 8'h00, 1'b0, 1'b0);
        wr(pol(16'h0, 2'b00, 1'b0, 1'b0, 8'hFF)); cyc(3);
        expect_out("R4 mode00 privacy high", 8'h00, 1'b0, 1'b0);

        // R5 static mode, R8 mask mapping
        privacy_raw = 1'b0;
        wr(pol(16'h0, 2'b11, 1'b0, 1'b0, 8'h81)); cyc(3);
        expect_out("R5 static privacy low", 8'h81, 1'b1, 1'b1);
        privacy_raw = 1'b1; cyc(5);
        expect_out("R5 static privacy high", 8'h81, 1'b1, 1'b1);

        // R6 dynamic timeout of 3 ticks
        privacy_raw = 1'b0;
        wr(pol(16'd3, 2'b10, 1'b0, 1'b0, 8'h3C)); cyc(4);
        expect_out("R6 dyn idle", 8'h00, 1'b0, 1'b0);
        privacy_raw = 1'b1; cyc(10);
        expect_out("R6 no ticks no zero", 8'h00, 1'b0, 1'b0);
        pulse(2); cyc(2);
        expect_out("R6 two of three ticks", 8'h00, 1'b0, 1'b0);
        pulse(1); cyc(2);
        expect_out("R6 R8 R9 expiry zeroes mask", 8'h3C, 1'b1, 1'b0);

        // R7 immediate release and count restart
        privacy_raw = 1'b0; cyc(3);
        expect_out("R7 release at once", 8'h00, 1'b0, 1'b0);
        privacy_raw = 1'b1; cyc(4);
        pulse(2);
        privacy_raw = 1'b0; cyc(4);
        privacy_raw = 1'b1; cyc(4);
        pulse(2); cyc(3);
        expect_out("R7 partial count discarded", 8'h00, 1'b0, 1'b0);
        pulse(1); cyc(2);
        expect_out("R7 full recount zeroes", 8'h3C, 1'b1, 1'b0);

        // R11 firmware takeover
        fw_managed = 1'b1; cyc(2);
        expect_out("R11 fw gates outputs", 8'h00, 1'b0, 1'b0);
        fw_managed = 1'b0; cyc(4);
        expect_out("R11 timeout restarted after fw", 8'h00, 1'b0, 1'b0);
        pulse(3); cyc(2);
        expect_out("R11 zero after new timeout", 8'h3C, 1'b1, 1'b0);

        // R12 final tick and fw takeover in the same cycle
        privacy_raw = 1'b0; cyc(4);
        wr(pol(16'd1, 2'b10, 1'b0, 1'b0, 8'h3C));
        privacy_raw = 1'b1; cyc(4);
        @(negedge clk); rtc_tick = 1'b1; fw_managed = 1'b1;
        @(negedge clk); rtc_tick = 1'b0;
        cyc(2);
        expect_out("R12 fw wins over expiry", 8'h00, 1'b0, 1'b0);
        fw_managed = 1'b0; cyc(4);
        expect_out("R12 no zero after fw release", 8'h00, 1'b0, 1'b0);
        pulse(1); cyc(2);
        expect_out("R12 one tick then zero", 8'h3C, 1'b1, 1'b0);

        // R10 deglitch filter
        privacy_raw = 1'b0; cyc(4);
        wr(pol(16'd0, 2'b10, 1'b1, 1'b0, 8'h0F)); cyc(2);
        privacy_raw = 1'b1; cyc(3);
        pulse(3); cyc(3);
        expect_out("R10 three ticks not enough", 8'h00, 1'b0, 1'b0);
        privacy_raw = 1'b0; cyc(3);
        privacy_raw = 1'b1; cyc(3);
        pulse(3); cyc(3);
        expect_out("R10 glitch resets count", 8'h00, 1'b0, 1'b0);
        pulse(1); cyc(4);
        expect_out("R10 fourth tick accepts", 8'h0F, 1'b1, 1'b0);

        // R3 lock
        privacy_raw = 1'b0;
        wr(pol(16'd5, 2'b11, 1'b0, 1'b1, 8'hFF)); cyc(2);
        chk_rd("R3 locking write stored", 32'h0FFB_0005);
        expect_out("R3 locked static", 8'hFF, 1'b1, 1'b1);
        wr(32'h0); cyc(2);
        chk_rd("R3 write ignored when locked", 32'h0FFB_0005);
        expect_out("R3 outputs unchanged", 8'hFF, 1'b1, 1'b1);
        do_reset();
        chk_rd("R3 reset clears lock", 32'h0);
        wr(pol(16'd0, 2'b01, 1'b0, 1'b0, 8'h00));
        chk_rd("R3 write after reset", 32'h0001_0000);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule